// File: doc/BRIEF.md
# Dual-Edge Pin Event Interrupt Unit

This block watches 31 already-synchronised input pins and turns their transitions into sticky event flags held in two status words. Each pin owns a polarity bit that names which transition counts as its "assert" event. Its enable bit decides whether the pin's transitions are recorded at all. An assert-type transition lands in the assert status word. The opposite transition lands in the deassert status word. Each status word drives its own interrupt request line.

Software reaches the block through a simple register port with four word addresses. The two status words share one write convention, selected by the low bit of the written word. With that bit at 0, every flag written as 1 is cleared. With that bit at 1, every flag written as 1 is set. Flags written as 0 keep their value in both cases. This lets a handler acknowledge exactly the events it has serviced, and lets test software inject events. A transition arriving in the same cycle as a clearing write keeps its flag set, so no event is lost.

Top module: `pin_event_irq`

## Requirements
- R1: After reset the enable, polarity and both status words read 0, and both interrupt lines are low.
- R2: Address 0 holds the enable word and address 1 the polarity word. Pin n maps to bit n in both, and bit 31 of either word reads 0.
- R3: Address 2 holds the assert status word and address 3 the deassert status word. Pin n maps to bit n+1, and bit 0 always reads 0.
- R4: With a pin's polarity bit at 1, a rising transition sets its assert flag and a falling transition sets its deassert flag.
- R5: With a pin's polarity bit at 0, a falling transition sets its assert flag and a rising transition sets its deassert flag.
- R6: A transition is recorded only if the pin's enable bit is 1 in the cycle the transition is seen. Enabling the pin later does not recover the event.
- R7: A status write with bit 0 equal to 0 clears every flag written as 1 and leaves the other flags unchanged.
- R8: A status write with bit 0 equal to 1 sets every flag written as 1 and leaves the other flags unchanged.
- R9: When a clearing write and a new recorded transition hit the same flag in the same cycle, the flag ends up set.
- R10: Each interrupt line is high exactly when some flag of its status word has its pin's enable bit set. It stays high until those flags are cleared or disabled.
- R11: A flag is set at the first clock edge that sees the pin change. Each interrupt line follows its status one clock edge later. Read data appears one clock edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 2 | Word address (0 enable, 1 polarity, 2 assert status, 3 deassert status) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data for the address of the previous cycle |
| pins_in | input | 31 | Synchronised pin levels |
| irq_assert | output | 1 | Interrupt from pending enabled assert flags |
| irq_deassert | output | 1 | Interrupt from pending enabled deassert flags |

## Verification
A pin change is driven at a falling clock edge. The status flag is captured at the next rising edge, so a read that puts its address out at the following falling edge sees the flag on the registered read data one edge later. Interrupt lines are registered from status, so each is sampled two falling edges after a pin change. For a register write, the line is sampled one falling edge after the write task returns. Just before that point, the line is also sampled once to confirm it has not yet moved. The race between a clearing write and a new transition is produced by driving both at the same falling edge, so both meet at one rising edge.

// File: rtl/pin_evt_pkg.sv
package pin_evt_pkg;
  localparam int ADDR_W    = 2;
  localparam int NUM_BANKS = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_EN  = 2'd0,
    SEL_POL = 2'd1,
    SEL_AST = 2'd2,
    SEL_DEA = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pin_edge_detect.sv
module pin_edge_detect #(
  parameter int NUM_PINS = 31
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pins,
  input  logic [NUM_PINS-1:0] enable,
  input  logic [NUM_PINS-1:0] polarity,
  output logic [NUM_PINS-1:0] ev_assert,
  output logic [NUM_PINS-1:0] ev_deassert
);
  logic [NUM_PINS-1:0] pin_q;

  always_ff @(posedge clk) begin
    if (rst) pin_q <= '0;
    else     pin_q <= pins;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic rise, fall;
    always_comb begin
      rise           = pins[i] & ~pin_q[i];
      fall           = ~pins[i] & pin_q[i];
      ev_assert[i]   = enable[i] & (polarity[i] ? rise : fall);
      ev_deassert[i] = enable[i] & (polarity[i] ? fall : rise);
    end
  end
endmodule

// File: rtl/pin_status_bank.sv
module pin_status_bank #(
  parameter int NUM_PINS = 31
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_hit,
  input  logic                wr_set,
  input  logic [NUM_PINS-1:0] wr_mask,
  input  logic [NUM_PINS-1:0] events,
  input  logic [NUM_PINS-1:0] enable,
  output logic [NUM_PINS-1:0] status,
  output logic                irq
);
  logic [NUM_PINS-1:0] st_q, st_nxt;
  logic                irq_q;

  always_comb begin
    st_nxt = st_q;
    if (wr_hit) begin
      if (wr_set) st_nxt = st_q | wr_mask;
      else        st_nxt = st_q & ~wr_mask;
    end
    st_nxt = st_nxt | events;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      st_q  <= st_nxt;
      irq_q <= |(st_q & enable);
    end
  end

  assign status = st_q;
  assign irq    = irq_q;
endmodule

// File: rtl/pin_event_irq.sv
module pin_event_irq
  import pin_evt_pkg::*;
#(
  parameter int NUM_PINS = 31,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  input  logic [NUM_PINS-1:0] pins_in,
  output logic                irq_assert,
  output logic                irq_deassert
);
  localparam int ST_MSB = NUM_PINS;

  logic [NUM_PINS-1:0] en_q, pol_q;
  logic [NUM_PINS-1:0] ev_w  [NUM_BANKS];
  logic [NUM_PINS-1:0] st_w  [NUM_BANKS];
  logic                irq_w [NUM_BANKS];
  logic [DATA_W-1:0]   rd_q, rd_nxt;

  initial begin
    if (DATA_W < NUM_PINS + 1) $error("DATA_W too small for NUM_PINS");
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      pol_q <= '0;
    end else if (wr_en) begin
      if (addr == SEL_EN)  en_q  <= wdata[NUM_PINS-1:0];
      if (addr == SEL_POL) pol_q <= wdata[NUM_PINS-1:0];
    end
  end

  pin_edge_detect #(.NUM_PINS(NUM_PINS)) u_edge (
    .clk        (clk),
    .rst        (rst),
    .pins       (pins_in),
    .enable     (en_q),
    .polarity   (pol_q),
    .ev_assert  (ev_w[0]),
    .ev_deassert(ev_w[1])
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam reg_sel_e BANK_SEL = (b == 0) ? SEL_AST : SEL_DEA;
    logic hit;
    assign hit = wr_en && (addr == BANK_SEL);
    pin_status_bank #(.NUM_PINS(NUM_PINS)) u_bank (
      .clk    (clk),
      .rst    (rst),
      .wr_hit (hit),
      .wr_set (wdata[0]),
      .wr_mask(wdata[ST_MSB:1]),
      .events (ev_w[b]),
      .enable (en_q),
      .status (st_w[b]),
      .irq    (irq_w[b])
    );
  end

  always_comb begin
    rd_nxt = '0;
    case (addr)
      SEL_EN:  rd_nxt[NUM_PINS-1:0] = en_q;
      SEL_POL: rd_nxt[NUM_PINS-1:0] = pol_q;
      SEL_AST: rd_nxt[ST_MSB:1]     = st_w[0];
      default: rd_nxt[ST_MSB:1]     = st_w[1];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_nxt;
  end

  assign rdata        = rd_q;
  assign irq_assert   = irq_w[0];
  assign irq_deassert = irq_w[1];
endmodule

// File: rtl/pin_event_irq_chk.sv
module pin_event_irq_chk
  import pin_evt_pkg::*;
#(
  parameter int NUM_PINS = 31,
  parameter int DATA_W   = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic [ADDR_W-1:0]   addr,
  input logic [DATA_W-1:0]   rdata,
  input logic [NUM_PINS-1:0] en,
  input logic [NUM_PINS-1:0] pol,
  input logic [NUM_PINS-1:0] st_a,
  input logic [NUM_PINS-1:0] st_d,
  input logic                irq_a,
  input logic                irq_d
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (st_a == '0 && st_d == '0 && en == '0 && pol == '0 && !irq_a && !irq_d)); // R1

  AST_STATUS_BIT0: assert property (@(posedge clk) disable iff (rst)
    (addr == SEL_AST || addr == SEL_DEA) |=> (rdata[0] == 1'b0)); // R3

  AST_NO_DISABLED_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == SEL_AST) |=> ((st_a & ~$past(st_a) & ~$past(en)) == '0)); // R6

  AST_ONE_KIND_PER_EDGE: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && (addr == SEL_AST || addr == SEL_DEA))
      |=> (((st_a & ~$past(st_a)) & (st_d & ~$past(st_d))) == '0)); // R4

  AST_IRQ_ASSERT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_a == $past(|(st_a & en)))); // R10

  AST_IRQ_DEASSERT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_d == $past(|(st_d & en)))); // R10
endmodule

bind pin_event_irq pin_event_irq_chk #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .wr_en(wr_en),
  .addr (addr),
  .rdata(rdata),
  .en   (en_q),
  .pol  (pol_q),
  .st_a (st_w[0]),
  .st_d (st_w[1]),
  .irq_a(irq_assert),
  .irq_d(irq_deassert)
);

// File: tb/pin_event_irq_tb.sv
`timescale 1ns/1ps
module pin_event_irq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [30:0] pins = '0;
  logic        irq_assert, irq_deassert;
  int          n_checks = 0;
  int          n_fails  = 0;

  localparam logic [1:0] A_EN = 2'd0, A_POL = 2'd1, A_AST = 2'd2, A_DEA = 2'd3;
  localparam logic [31:0] CLR_ALL = 32'hFFFF_FFFE;

  always #2 clk = ~clk;

  pin_event_irq u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pins_in(pins), .irq_assert(irq_assert), .irq_deassert(irq_deassert)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    v = rdata;
  endtask

  task automatic set_pin(input int i, input logic v);
    @(negedge clk);
    pins[i] = v;
  endtask

  task automatic clear_all();
    wr(A_AST, CLR_ALL);
    wr(A_DEA, CLR_ALL);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq_assert in reset", {31'd0, irq_assert}, 32'd0);
    chk("R1 irq_deassert in reset", {31'd0, irq_deassert}, 32'd0);
    @(negedge clk); rst = 1'b0;
    rd(A_EN, v);  chk("R1 enable after reset", v, 32'd0);
    rd(A_POL, v); chk("R1 polarity after reset", v, 32'd0);
    rd(A_AST, v); chk("R1 assert status after reset", v, 32'd0);
    rd(A_DEA, v); chk("R1 deassert status after reset", v, 32'd0);
  endtask

  task automatic t_config();
    logic [31:0] v;
    wr(A_EN, 32'hFFFF_FFFF);
    rd(A_EN, v);  chk("R2 enable readback, bit31 zero", v, 32'h7FFF_FFFF);
    wr(A_POL, 32'h8000_00A5);
    rd(A_POL, v); chk("R2 polarity readback", v, 32'h0000_00A5);
    wr(A_POL, 32'h0000_0009);  // pins 0 and 3 rising-assert
    wr(A_EN, 32'h7FFF_FFFF);
  endtask

  task automatic t_pol_high();
    logic [31:0] v;
    set_pin(0, 1'b1);
    rd(A_AST, v); chk("R4 R3 rise pin0 -> assert bit1", v, 32'h0000_0002);
    rd(A_DEA, v); chk("R4 rise pin0 leaves deassert", v, 32'h0);
    set_pin(0, 1'b0);
    rd(A_DEA, v); chk("R4 fall pin0 -> deassert bit1", v, 32'h0000_0002);
    clear_all();
    rd(A_AST, v); chk("R7 clear all assert", v, 32'h0);
  endtask

  task automatic t_pol_low();
    logic [31:0] v;
    set_pin(30, 1'b1);
    rd(A_DEA, v); chk("R5 rise pin30 -> deassert bit31", v, 32'h8000_0000);
    rd(A_AST, v); chk("R5 rise pin30 leaves assert", v, 32'h0);
    set_pin(30, 1'b0);
    rd(A_AST, v); chk("R5 fall pin30 -> assert bit31", v, 32'h8000_0000);
    clear_all();
  endtask

  task automatic t_enable_gate();
    logic [31:0] v;
    wr(A_EN, 32'h7FFF_FFDF);  // pin5 disabled, polarity 0
    set_pin(5, 1'b1);
    set_pin(5, 1'b0);
    wr(A_EN, 32'h7FFF_FFFF);
    rd(A_AST, v); chk("R6 disabled pin5 not recorded (assert)", v, 32'h0);
    rd(A_DEA, v); chk("R6 disabled pin5 not recorded (deassert)", v, 32'h0);
  endtask

  task automatic t_set_clear();
    logic [31:0] v;
    wr(A_AST, 32'h0000_0015);  // set mode, pins 1 and 3
    rd(A_AST, v); chk("R8 set mode marks pins 1,3", v, 32'h0000_0014);
    wr(A_AST, 32'h0000_0004);  // clear mode, pin 1
    rd(A_AST, v); chk("R7 clear pin1 keeps pin3", v, 32'h0000_0010);
    wr(A_DEA, 32'h0000_0101);  // set mode, pin 7
    rd(A_DEA, v); chk("R8 set mode on deassert", v, 32'h0000_0100);
    rd(A_AST, v); chk("R8 deassert write leaves assert", v, 32'h0000_0010);
    wr(A_DEA, CLR_ALL);
  endtask

  task automatic t_edge_wins();
    logic [31:0] v;
    @(negedge clk);
    wr_en = 1'b1; addr = A_AST; wdata = 32'h0000_0010; pins[3] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    rd(A_AST, v); chk("R9 edge beats clear on pin3", v, 32'h0000_0010);
    wr(A_AST, 32'h0000_0010);
    rd(A_AST, v); chk("R7 later clear of pin3", v, 32'h0);
    set_pin(3, 1'b0);
    clear_all();
  endtask

  task automatic t_irq();
    wr(A_AST, 32'h0000_0009);  // set pin 2 flag
    chk("R11 irq one edge behind status", {31'd0, irq_assert}, 32'd0);
    @(negedge clk);
    chk("R10 irq_assert on pending flag", {31'd0, irq_assert}, 32'd1);
    chk("R10 irq_deassert idle", {31'd0, irq_deassert}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R10 irq_assert held", {31'd0, irq_assert}, 32'd1);
    wr(A_EN, 32'h7FFF_FFFB);   // disable pin2
    @(negedge clk);
    chk("R10 irq masked by enable", {31'd0, irq_assert}, 32'd0);
    wr(A_EN, 32'h7FFF_FFFF);
    @(negedge clk);
    chk("R10 irq back when re-enabled", {31'd0, irq_assert}, 32'd1);
    wr(A_AST, 32'h0000_0008);
    @(negedge clk);
    chk("R10 irq drops after clear", {31'd0, irq_assert}, 32'd0);
    set_pin(3, 1'b1);
    set_pin(3, 1'b0);
    repeat (2) @(negedge clk);
    chk("R11 R10 irq_deassert from pin fall", {31'd0, irq_deassert}, 32'd1);
    clear_all();
    @(negedge clk);
    chk("R10 all irqs low after clear", {30'd0, irq_assert, irq_deassert}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_config();
    t_pol_high();
    t_pol_low();
    t_enable_gate();
    t_set_clear();
    t_edge_wins();
    t_irq();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL R11 watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule